// File: doc/BRIEF.md
# Vector Branch Condition Evaluator

This block decides a conditional branch over a vector of 4-bit condition fields. A start pulse captures a vector length, a predicate mask, a starting field index and a set of option flags. The unit then walks the elements from index 0 upward, in strict order. For each element that is enabled, it reads one condition field from an external condition array. It tests one selected bit of that field against two branch-option bits and merges the results into a single branch decision.

Two merge modes are offered. In ALL mode every tested element must pass. In ANY mode one passing element is enough. Evaluation stops at the first element that decides the outcome, and later elements are never read. Masked-out elements are either skipped or tested with a constant substitute bit. An optional truncation mode shrinks the vector length at the first failing element. A counter reports how many unmasked elements were tested. When write-back is enabled, each field that was read is copied into a destination array at an offset given by the element number.

The block has no stream interface. Its array ports are plain synchronous memory ports, and its control pins are a start pulse with busy and done levels. There is no back-pressure: the read data must arrive one cycle after the read strobe, and every write strobe is taken in the cycle it is asserted.

Top module: `vbranch_eval`

## Requirements
- R1: The element test bit is bit `bit_sel` of the 4-bit field (bit 0 EQ, 1 LT, 2 GT, 3 SO). An element passes when `opt_uncond | ~(testbit ^ opt_pol)`.
- R2: With `mode_all`=1 the result starts at 1 and is ANDed with each element result. Evaluation stops at the first failing element, and `taken` is then 0.
- R3: With `mode_all`=0 the result starts at 0 and is ORed with each element result. Evaluation stops at the first passing element, and `taken` is then 1.
- R4: Element i reads field index `(base_fld + i) mod 2^FW`. No element beyond the stop point, and no masked-out element, is ever read.
- R5: An element with predicate bit 0 and `zero_en`=0 is skipped. It is not read, tested or counted. With an all-zero mask, the result equals that of a zero vector length.
- R6: An element with predicate bit 0 and `zero_en`=1 is tested with `snz_bit` as its test bit. No field is read for it, and it is not counted.
- R7: With `vlset_en`=1, the first failing element i stops evaluation. `vl_out` becomes i+1 if `vl_incl`=1 and i otherwise, and `vl_trunc`=1. In every other case `vl_out` equals the captured length and `vl_trunc`=0.
- R8: `test_cnt` equals the number of unmasked elements tested before the stop.
- R9: With `wb_en`=1, each field that is read is written once to index `(wb_base + i) mod 2^FW` with unchanged data. With `wb_en`=0 nothing is written.
- R10: With a captured length of 0, `done` rises in the cycle after start. `taken` then equals `mode_all`, and no field is read.
- R11: `start` is accepted only while the unit is idle or done. The outputs stay constant while `done` is held, until the next start.
- R12: After reset, `busy`, `done`, `rd_en` and `wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture the inputs and begin an evaluation |
| cfg_vl | input | VLW | Vector length (0..MAXVL) |
| pred_mask | input | MAXVL | Predicate bit per element |
| base_fld | input | FW | Field index of element 0 |
| bit_sel | input | 2 | Bit within the field: EQ, LT, GT, SO |
| opt_uncond | input | 1 | Every element passes |
| opt_pol | input | 1 | 1: a set bit passes, 0: a clear bit passes |
| mode_all | input | 1 | 1: AND of all elements, 0: OR of any element |
| zero_en | input | 1 | Test masked elements with a substitute bit |
| snz_bit | input | 1 | Substitute test bit for masked elements |
| vlset_en | input | 1 | Truncate the length at the first failure |
| vl_incl | input | 1 | Truncated length includes the failing element |
| wb_en | input | 1 | Copy the fields read to the destination array |
| wb_base | input | FW | Destination index of element 0 |
| rd_en | output | 1 | Condition array read strobe |
| rd_idx | output | FW | Condition array read index |
| rd_data | input | 4 | Read data, valid one cycle after `rd_en` |
| wr_en | output | 1 | Destination write strobe |
| wr_idx | output | FW | Destination write index |
| wr_data | output | 4 | Destination write data |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | Results valid |
| taken | output | 1 | Branch decision |
| vl_out | output | VLW | Resulting vector length |
| vl_trunc | output | 1 | Length was truncated |
| test_cnt | output | VLW | Number of unmasked elements tested |

## Verification
Latency depends on the data. A skipped element takes one cycle, an element tested with the substitute bit takes one cycle, and an element that needs a read takes two. Finishing adds one more cycle. A zero length is the one fixed case: `done` must be high in the cycle right after start.

For every other case, the bench polls `done` on falling edges under a per-job bound. It then compares all result ports against a model computed from the requirements, together with the read and write traffic it observed during that job. On some jobs it samples again two cycles later to confirm that the results hold while `done` stays high.

// File: rtl/vbe_pkg.sv
package vbe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } vbe_state_e;

  typedef struct packed {
    logic       uncond;
    logic       pol;
    logic       all;
    logic       zero;
    logic       snz;
    logic       vlset;
    logic       incl;
    logic       wb;
    logic [1:0] bsel;
  } vbe_opts_t;
endpackage

// File: rtl/vbe_elem_test.sv
module vbe_elem_test (
  input  logic [3:0] fld,
  input  logic [1:0] bsel,
  input  logic       masked,
  input  logic       snz,
  input  logic       uncond,
  input  logic       pol,
  output logic       pass
);
  logic tbit;

  always_comb begin
    tbit = masked ? snz : fld[bsel];
    pass = uncond | ~(tbit ^ pol);
  end
endmodule

// File: rtl/vbe_merge.sv
module vbe_merge (
  input  logic mode_all,
  input  logic vlset,
  input  logic acc_in,
  input  logic pass,
  output logic acc_out,
  output logic stop,
  output logic trunc
);
  always_comb begin
    acc_out = mode_all ? (acc_in & pass) : (acc_in | pass);
    trunc   = vlset & ~pass;
    stop    = trunc | (mode_all ? ~pass : pass);
  end
endmodule

// File: rtl/vbranch_eval.sv
module vbranch_eval
  import vbe_pkg::*;
#(
  parameter int MAXVL = 64,
  parameter int FW    = 7,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int IW   = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VLW-1:0]   cfg_vl,
  input  logic [MAXVL-1:0] pred_mask,
  input  logic [FW-1:0]    base_fld,
  input  logic [1:0]       bit_sel,
  input  logic             opt_uncond,
  input  logic             opt_pol,
  input  logic             mode_all,
  input  logic             zero_en,
  input  logic             snz_bit,
  input  logic             vlset_en,
  input  logic             vl_incl,
  input  logic             wb_en,
  input  logic [FW-1:0]    wb_base,
  output logic             rd_en,
  output logic [FW-1:0]    rd_idx,
  input  logic [3:0]       rd_data,
  output logic             wr_en,
  output logic [FW-1:0]    wr_idx,
  output logic [3:0]       wr_data,
  output logic             busy,
  output logic             done,
  output logic             taken,
  output logic [VLW-1:0]   vl_out,
  output logic             vl_trunc,
  output logic [VLW-1:0]   test_cnt
);
  vbe_state_e       state_q;
  vbe_opts_t        opt_q;
  logic [VLW-1:0]   vl_q, idx_q, cnt_q, vl_out_q;
  logic [MAXVL-1:0] pred_q;
  logic [FW-1:0]    base_q, wbase_q;
  logic             acc_q, taken_q, trunc_q;

  logic in_range, pred_bit, accept;
  logic ev_valid, ev_masked;
  logic pass, acc_n, stop, trunc_n;

  assign accept    = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign in_range  = (idx_q < vl_q);
  assign pred_bit  = pred_q[idx_q[IW-1:0]];
  assign ev_masked = (state_q == ST_ISSUE);
  assign ev_valid  = (state_q == ST_WAIT) ||
                     ((state_q == ST_ISSUE) && in_range && !pred_bit && opt_q.zero);

  vbe_elem_test u_test (
    .fld    (rd_data),
    .bsel   (opt_q.bsel),
    .masked (ev_masked),
    .snz    (opt_q.snz),
    .uncond (opt_q.uncond),
    .pol    (opt_q.pol),
    .pass   (pass)
  );

  vbe_merge u_merge (
    .mode_all (opt_q.all),
    .vlset    (opt_q.vlset),
    .acc_in   (acc_q),
    .pass     (pass),
    .acc_out  (acc_n),
    .stop     (stop),
    .trunc    (trunc_n)
  );

  always_comb begin
    rd_en   = (state_q == ST_ISSUE) && in_range && pred_bit;
    rd_idx  = base_q + FW'(idx_q);
    wr_en   = (state_q == ST_WAIT) && opt_q.wb;
    wr_idx  = wbase_q + FW'(idx_q);
    wr_data = rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      opt_q    <= '0;
      vl_q     <= '0;
      idx_q    <= '0;
      cnt_q    <= '0;
      vl_out_q <= '0;
      pred_q   <= '0;
      base_q   <= '0;
      wbase_q  <= '0;
      acc_q    <= 1'b0;
      taken_q  <= 1'b0;
      trunc_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            opt_q    <= '{uncond: opt_uncond, pol: opt_pol, all: mode_all,
                          zero: zero_en, snz: snz_bit, vlset: vlset_en,
                          incl: vl_incl, wb: wb_en, bsel: bit_sel};
            vl_q     <= cfg_vl;
            vl_out_q <= cfg_vl;
            pred_q   <= pred_mask;
            base_q   <= base_fld;
            wbase_q  <= wb_base;
            idx_q    <= '0;
            cnt_q    <= '0;
            acc_q    <= mode_all;
            taken_q  <= mode_all;
            trunc_q  <= 1'b0;
            state_q  <= (cfg_vl == '0) ? ST_DONE : ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (!in_range) begin
            taken_q <= acc_q;
            state_q <= ST_DONE;
          end else if (pred_bit) begin
            state_q <= ST_WAIT;
          end else if (!opt_q.zero) begin
            idx_q <= idx_q + VLW'(1);
          end
        end
        ST_WAIT: begin
          cnt_q <= cnt_q + VLW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase

      if (ev_valid) begin
        acc_q <= acc_n;
        if (stop) begin
          taken_q <= acc_n;
          state_q <= ST_DONE;
          if (trunc_n) begin
            trunc_q  <= 1'b1;
            vl_out_q <= opt_q.incl ? (idx_q + VLW'(1)) : idx_q;
          end
        end else begin
          idx_q   <= idx_q + VLW'(1);
          state_q <= ST_ISSUE;
        end
      end
    end
  end

  assign busy     = (state_q == ST_ISSUE) || (state_q == ST_WAIT);
  assign done     = (state_q == ST_DONE);
  assign taken    = taken_q;
  assign vl_out   = vl_out_q;
  assign vl_trunc = trunc_q;
  assign test_cnt = cnt_q;

  // R4/R5: a read is issued only for an unmasked element inside the length
  p_rd_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (in_range && pred_bit));

  // R9: a write follows a read in the previous cycle
  p_wr_after_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rd_en));

  // R10: a zero length finishes in the next cycle
  p_vl0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && start && cfg_vl == '0) |=> done);

  // R11: results hold while done is held and no start arrives
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(taken) && $stable(vl_out) &&
                          $stable(test_cnt) && $stable(vl_trunc)));

  // R8: the count never exceeds the captured length
  p_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (test_cnt <= vl_q));

  // R7: a truncated length is never longer than the captured one
  p_trunc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && vl_trunc) |-> (vl_out <= vl_q));

  // R12: busy and done never overlap
  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

// File: tb/vbranch_eval_tb.sv
module vbranch_eval_tb;
  localparam int MAXVL = 8;
  localparam int FW    = 7;
  localparam int VLW   = $clog2(MAXVL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             start = 1'b0;
  logic [VLW-1:0]   cfg_vl = '0;
  logic [MAXVL-1:0] pred_mask = '0;
  logic [FW-1:0]    base_fld = '0, wb_base = '0;
  logic [1:0]       bit_sel = '0;
  logic opt_uncond = 0, opt_pol = 0, mode_all = 0, zero_en = 0, snz_bit = 0;
  logic vlset_en = 0, vl_incl = 0, wb_en = 0;
  logic rd_en, wr_en, busy, done, taken, vl_trunc;
  logic [FW-1:0] rd_idx, wr_idx;
  logic [3:0] rd_data = '0, wr_data;
  logic [VLW-1:0] vl_out, test_cnt;

  vbranch_eval #(.MAXVL(MAXVL), .FW(FW)) u_dut (
    .clk, .rst_n, .start, .cfg_vl, .pred_mask, .base_fld, .bit_sel,
    .opt_uncond, .opt_pol, .mode_all, .zero_en, .snz_bit, .vlset_en,
    .vl_incl, .wb_en, .wb_base, .rd_en, .rd_idx, .rd_data, .wr_en,
    .wr_idx, .wr_data, .busy, .done, .taken, .vl_out, .vl_trunc, .test_cnt);

  logic [3:0] mem [128];
  int n_tests = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0, wr_sum = 0, rd_bad = 0;

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_idx];
      rd_cnt  <= rd_cnt + 1;
    end
    if (wr_en) begin
      wr_cnt <= wr_cnt + 1;
      wr_sum <= wr_sum + (int'(wr_idx) * 16 + int'(wr_data) + 1);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected results, from the requirements
  int e_taken, e_vl, e_trunc, e_cnt, e_rd, e_wr, e_sum;
  task automatic model();
    int acc, b, f, p;
    acc = mode_all; e_vl = cfg_vl; e_trunc = 0; e_cnt = 0;
    e_rd = 0; e_wr = 0; e_sum = 0;
    for (int i = 0; i < int'(cfg_vl); i++) begin
      if (pred_mask[i]) begin
        f = mem[(int'(base_fld) + i) % 128];
        b = (f >> bit_sel) & 1;
        e_cnt++; e_rd++;
        if (wb_en) begin
          e_wr++;
          e_sum += ((int'(wb_base) + i) % 128) * 16 + f + 1;
        end
      end else if (!zero_en) continue;
      else b = snz_bit;
      p = (opt_uncond || (b == int'(opt_pol))) ? 1 : 0;
      acc = mode_all ? (acc & p) : (acc | p);
      if (!p && vlset_en) begin
        e_vl = vl_incl ? i + 1 : i; e_trunc = 1; break;
      end
      if (mode_all && !p) break;
      if (!mode_all && p) break;
    end
    e_taken = acc;
  endtask

  task automatic run_job(input bit hold_chk);
    int rd0, wr0, sum0, t;
    @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt; sum0 = wr_sum;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (cfg_vl == '0) chk("R10 done after one cycle", int'(done), 1);
    t = 0;
    while (!done && t < 100) begin
      @(negedge clk); t++;
    end
    chk("R11 job completes", int'(done), 1);
    model();
    chk(mode_all ? "R2 taken" : "R3 taken", int'(taken), e_taken);
    chk("R7 vl_out", int'(vl_out), e_vl);
    chk("R7 vl_trunc", int'(vl_trunc), e_trunc);
    chk("R8 test_cnt", int'(test_cnt), e_cnt);
    chk("R4 reads", rd_cnt - rd0, e_rd);
    chk("R9 writes", wr_cnt - wr0, e_wr);
    chk("R9 write content", wr_sum - sum0, e_sum);
    if (hold_chk) begin
      repeat (2) @(negedge clk);
      chk("R11 done held", int'(done), 1);
      chk("R11 taken held", int'(taken), e_taken);
      chk("R11 vl held", int'(vl_out), e_vl);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int masks [4];
    int vls [3];
    masks = '{8'hFF, 8'hA5, 8'h00, 8'h3C};
    vls   = '{0, 3, 8};
    for (int k = 0; k < 128; k++) mem[k] = 4'((k * 7 + 3) ^ (k >> 3));
    repeat (3) @(negedge clk);
    chk("R12 busy at reset", int'(busy), 0);
    chk("R12 done at reset", int'(done), 0);
    chk("R12 rd_en at reset", int'(rd_en), 0);
    chk("R12 wr_en at reset", int'(wr_en), 0);
    rst_n = 1'b1;

    // R1 directed: field 0x2 (LT set), element 0 only
    mem[10] = 4'h2;
    cfg_vl = 1; pred_mask = 8'h01; base_fld = 10; mode_all = 0;
    for (int s = 0; s < 4; s++) begin
      bit_sel = 2'(s); opt_pol = 1'b1;
      run_job(1'b0);
      chk("R1 bit select", int'(taken), (s == 1) ? 1 : 0);
    end

    // R5: all-zero mask, no zeroing, equals zero length
    cfg_vl = 8; pred_mask = 8'h00; zero_en = 0;
    for (int m = 0; m < 2; m++) begin
      mode_all = m[0];
      run_job(1'b0);
      chk("R5 empty mask result", int'(taken), m);
    end

    // R6: all masked with zeroing, the substitute decides, nothing read
    zero_en = 1; mode_all = 1; opt_pol = 1; snz_bit = 1; opt_uncond = 0;
    run_job(1'b0);
    chk("R6 substitute one passes", int'(taken), 1);
    chk("R6 nothing counted", int'(test_cnt), 0);
    snz_bit = 0;
    run_job(1'b0);
    chk("R6 substitute zero fails", int'(taken), 0);

    // sweep
    for (int job = 0; job < 128 * 12; job++) begin
      int c;
      c = job % 128;
      {opt_uncond, opt_pol, mode_all, zero_en, snz_bit, vlset_en, vl_incl} = 7'(c);
      pred_mask = 8'(masks[(job / 128) % 4]);
      cfg_vl    = VLW'(vls[(job / 512) % 3]);
      bit_sel   = 2'(job / 3);
      base_fld  = 7'((job * 13) % 128);
      wb_base   = 7'((job * 5) % 128);
      wb_en     = job[2];
      run_job(job % 16 == 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule